// File: doc/BRIEF.md
# PCI Initiator Bus Acquisition Sequencer

This block takes a PCI-style bus for a local agent that wants to start a transfer. When the local side raises a transfer request, the block drives the active-low bus request and waits for the arbiter's active-low grant. It begins the address phase only on a clock edge where it samples the grant asserted and the shared FRAME line deasserted, meaning the bus is idle. It then drives FRAME low and waits for a target to claim the address by asserting DEVSEL.

If a target claims the cycle within the timeout window, the block gives a one-cycle claim pulse, drops its request and releases FRAME. If no target claims it, the block performs a master abort. It releases FRAME, holds the request deasserted for a back-off cycle and sets a sticky abort flag for the host. The host clears that flag with a write strobe. Data phases, parity and retry handling belong to other blocks.

Top module: `pci_bus_acquire`

## Requirements
- R1: After reset the block is idle with `req_n` = 1, `frame_oe` = 0, `frame_n_out` = 1, and `started`, `claimed` and `abort_flag` all 0.
- R2: A clock edge that samples `xfer_req` = 1 while idle drives `req_n` to 0 in the following cycle. `req_n` stays 0 through the waiting and address states.
- R3: The transaction starts only on an edge that samples `gnt_n` = 0 and `frame_in_n` = 1 together. In the next cycle `frame_oe` = 1, `frame_n_out` = 0 and `started` = 1 for exactly that one cycle. While grant is present but FRAME is low, no start happens.
- R4: If grant is absent or withdrawn before the start, the block keeps `req_n` = 0 and keeps waiting for grant.
- R5: An edge that samples `devsel_n` = 0 at any of the first TIMEOUT_CLKS edges after the start gives `claimed` = 1 for one cycle. In that cycle `req_n` = 1 and `frame_oe` = 0. A claim on the last edge of the window still counts as a claim and does not set the abort flag.
- R6: If `devsel_n` is sampled 1 at all TIMEOUT_CLKS (default 6) edges after the start, the next cycle has `frame_oe` = 0, `req_n` = 1 and `abort_flag` = 1. One back-off cycle follows, during which `xfer_req` is ignored, and then the block is idle again, so `req_n` stays 1 for at least two cycles.
- R7: `abort_flag` stays set until an edge samples `abort_clr` = 1. If an abort and a clear occur on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_req | input | 1 | Local request to start a bus transaction |
| gnt_n | input | 1 | Arbiter grant, active low |
| frame_in_n | input | 1 | Sampled bus FRAME, active low |
| devsel_n | input | 1 | Sampled bus DEVSEL, active low |
| abort_clr | input | 1 | Host write strobe that clears the abort flag |
| req_n | output | 1 | Bus request to the arbiter, active low |
| frame_n_out | output | 1 | FRAME value to drive, active low |
| frame_oe | output | 1 | Output enable for FRAME; 0 means three-stated |
| started | output | 1 | One-cycle pulse in the first address cycle |
| claimed | output | 1 | One-cycle pulse after a target claims the cycle |
| abort_flag | output | 1 | Sticky master-abort status |

## Verification
The bench builds the block with the default TIMEOUT_CLKS of 6, so the whole claim window, a claim on the sixth edge and the abort boundary one edge later are all reached in a handful of cycles. A small timeout also means random DEVSEL activity ends both in claims and in aborts often. Random back-to-back requests then hit the back-off cycle, grant withdrawal while waiting, and a busy FRAME under grant many times.

// File: rtl/pci_acq_pkg.sv
package pci_acq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ASK     = 2'd1,
    ST_ADDR    = 2'd2,
    ST_BACKOFF = 2'd3
  } acq_state_e;

  // Count value at which the last DEVSEL sample of the window is taken.
  function automatic int unsigned last_sample_idx(input int unsigned window);
    return (window > 0) ? window - 1 : 0;
  endfunction

  // True when the bus may be taken on this edge.
  function automatic logic bus_takeable(input logic gnt_low_n, input logic frame_n);
    return (!gnt_low_n) && frame_n;
  endfunction

endpackage

// File: rtl/acq_devsel_timer.sv
module acq_devsel_timer
  import pci_acq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hit,
  output logic first,
  output logic expire
);
  localparam int unsigned CW   = (TIMEOUT_CLKS > 1) ? $clog2(TIMEOUT_CLKS) : 1;
  localparam int unsigned LAST = last_sample_idx(TIMEOUT_CLKS);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == CW'(LAST));
  assign first   = run && (cnt_q == '0);
  assign expire  = run && !hit && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || hit || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LAST)); // R6

  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/acq_abort_latch.sv
module acq_abort_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (clr_evt) begin
      flag <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_evt |=> flag); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag); // R7

endmodule

// File: rtl/pci_bus_acquire.sv
module pci_bus_acquire
  import pci_acq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_req,
  input  logic gnt_n,
  input  logic frame_in_n,
  input  logic devsel_n,
  input  logic abort_clr,
  output logic req_n,
  output logic frame_n_out,
  output logic frame_oe,
  output logic started,
  output logic claimed,
  output logic abort_flag
);
  acq_state_e state_q, state_d;
  logic       in_addr;
  logic       claim_evt;
  logic       abort_evt;
  logic       take_bus;
  logic       first_addr;
  logic       claimed_q;

  assign in_addr   = (state_q == ST_ADDR);
  assign claim_evt = in_addr && !devsel_n;
  assign take_bus  = (state_q == ST_ASK) && bus_takeable(gnt_n, frame_in_n);

  acq_devsel_timer #(
    .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_addr),
    .hit   (!devsel_n),
    .first (first_addr),
    .expire(abort_evt)
  );

  acq_abort_latch u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(abort_evt),
    .clr_evt(abort_clr),
    .flag   (abort_flag)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (xfer_req) state_d = ST_ASK;
      ST_ASK:     if (take_bus) state_d = ST_ADDR;
      ST_ADDR: begin
        if (claim_evt)      state_d = ST_IDLE;
        else if (abort_evt) state_d = ST_BACKOFF;
      end
      ST_BACKOFF: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      claimed_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      claimed_q <= claim_evt;
    end
  end

  assign req_n       = !((state_q == ST_ASK) || in_addr);
  assign frame_oe    = in_addr;
  assign frame_n_out = !in_addr;
  assign started     = first_addr;
  assign claimed     = claimed_q;

  AST_START_NEEDS_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_oe) |-> $past(!gnt_n && frame_in_n)); // R3

  AST_START_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> !started); // R3

  AST_REQ_HELD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !frame_oe && gnt_n) |=> !req_n); // R4

  AST_CLAIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    claimed |=> !claimed); // R5

  AST_CLAIM_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    claimed |-> (req_n && !frame_oe)); // R5

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (req_n && !frame_oe && abort_flag)); // R6

  AST_BACKOFF_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> ##1 req_n); // R6

endmodule

// File: tb/test_pci_bus_acquire.sv
module test_pci_bus_acquire;
  localparam int TMO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_req = 1'b0, gnt_n = 1'b1, frame_in_n = 1'b1, devsel_n = 1'b1, abort_clr = 1'b0;
  logic req_n, frame_n_out, frame_oe, started, claimed, abort_flag;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  pci_bus_acquire #(.TIMEOUT_CLKS(TMO)) i_pci_bus_acquire (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .gnt_n(gnt_n),
    .frame_in_n(frame_in_n), .devsel_n(devsel_n), .abort_clr(abort_clr),
    .req_n(req_n), .frame_n_out(frame_n_out), .frame_oe(frame_oe),
    .started(started), .claimed(claimed), .abort_flag(abort_flag)
  );

  // Reference model: 0 idle, 1 asking, 2 address, 3 back-off
  int m_ph = 0, m_n = 0;
  bit m_claim = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_n = 0; m_claim = 0; m_flag = 0;
    end else begin
      bit ab;
      ab = 0;
      m_claim = 0;
      case (m_ph)
        0: if (xfer_req) m_ph = 1;
        1: if (!gnt_n && frame_in_n) begin m_ph = 2; m_n = 0; end
        2: if (!devsel_n) begin m_ph = 0; m_claim = 1; end
           else begin
             m_n++;
             if (m_n == TMO) begin m_ph = 3; ab = 1; end
           end
        default: m_ph = 0;
      endcase
      if (ab) m_flag = 1;
      else if (abort_clr) m_flag = 0;
    end
  end

  function automatic bit exp_req_n(int ph);
    return !(ph == 1 || ph == 2);
  endfunction
  function automatic bit exp_start(int ph, int n);
    return (ph == 2) && (n == 0);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 req_n", req_n, exp_req_n(m_ph));
    check("R3 frame_oe", frame_oe, m_ph == 2);
    check("R3 frame_n_out", frame_n_out, m_ph != 2);
    check("R3 started", started, exp_start(m_ph, m_n));
    check("R5 claimed", claimed, m_claim);
    check("R7 abort_flag", abort_flag, m_flag);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_n", req_n, 1'b1);
    check("R1 frame_oe", frame_oe, 1'b0);
    check("R1 frame_n_out", frame_n_out, 1'b1);
    check("R1 started", started, 1'b0);
    check("R1 claimed", claimed, 1'b0);
    check("R1 abort_flag", abort_flag, 1'b0);

    // Abort path, with grant absent at first
    xfer_req = 1; cyc();
    check("R2 req low", req_n, 1'b0);
    xfer_req = 0; cyc();
    check("R4 req held without grant", req_n, 1'b0);
    gnt_n = 0; cyc();
    check("R3 start pulse", started, 1'b1);
    gnt_n = 1;
    for (int i = 0; i < TMO - 1; i++) cyc();
    check("R6 still driving before last edge", frame_oe, 1'b1);
    cyc();
    check("R6 flag set", abort_flag, 1'b1);
    check("R6 frame released", frame_oe, 1'b0);
    check("R6 req high", req_n, 1'b1);
    xfer_req = 1; cyc();
    check("R6 back-off ignores request", req_n, 1'b1);
    cyc();
    check("R7 flag kept", abort_flag, 1'b1);
    xfer_req = 0; cyc();
    abort_clr = 1; cyc();
    check("R7 flag cleared", abort_flag, 1'b0);
    abort_clr = 0;

    // Claim on the last edge of the window
    xfer_req = 1; cyc();
    xfer_req = 0; gnt_n = 0; cyc();
    gnt_n = 1;
    for (int i = 0; i < TMO - 1; i++) cyc();
    devsel_n = 0; cyc();
    check("R5 late claim", claimed, 1'b1);
    check("R5 no abort", abort_flag, 1'b0);
    check("R5 req released", req_n, 1'b1);
    devsel_n = 1; cyc();
    check("R5 claim one cycle", claimed, 1'b0);

    // Grant with busy bus, then withdrawn, then bus idle
    xfer_req = 1; cyc();
    xfer_req = 0; gnt_n = 0; frame_in_n = 0; cyc();
    check("R3 no start on busy bus", frame_oe, 1'b0);
    gnt_n = 1; frame_in_n = 1; cyc();
    check("R4 grant withdrawn keeps req", req_n, 1'b0);
    gnt_n = 0; cyc();
    check("R3 start after idle bus", frame_oe, 1'b1);
    gnt_n = 1; devsel_n = 0; cyc();
    check("R5 immediate claim", claimed, 1'b1);
    devsel_n = 1;

    // Constrained random
    for (int k = 0; k < 4000; k++) begin
      xfer_req   = ($urandom % 3) == 0;
      gnt_n      = ($urandom % 2) == 0;
      frame_in_n = ($urandom % 4) != 0;
      devsel_n   = ($urandom % 9) != 0;
      abort_clr  = ($urandom % 16) == 0;
      cyc();
    end
    finish_run();
  end
endmodule